// File: doc/BRIEF.md
# Merging Write Buffer with Read Bypass

This block sits between a write-through cache and main memory and holds stores until memory accepts them. Each of its entries stands for one aligned memory block of four 64-bit words: it keeps the block number, one valid bit for each word slot, and the word data. A store to a block that an entry already holds, and that is not being sent to memory, is written into that entry. It does not use a second entry. As a result, a run of stores to neighbouring words leaves memory as a single masked block write instead of several partial ones.

A read that missed in the cache looks the buffer up in the same cycle. If the requested word sits in the buffer, the read takes it from there, so it never sees stale memory data. Entries go to memory oldest first, one block transaction at a time, through a valid/ready handshake.

The drain control is a two-state machine. In `DR_IDLE` nothing is offered to memory. The transition `start_drain` (the buffer is not empty) moves it to `DR_SEND`. In `DR_SEND` the oldest entry is presented to memory. The transition `retire` (memory ready) frees that entry and returns the machine to `DR_IDLE`. While it stays in `DR_SEND` (transition `hold`), the offered transaction does not change.

Top module: `merge_write_buffer`

## Requirements
- R1: After reset the buffer is empty: `empty`=1, `full`=0, `mem_valid`=0 and `rd_hit`=0.
- R2: For a byte address, bits [2:0] are ignored, bits [4:3] select the word slot (slot 0 holds the lowest address), and bits [31:5] are the block number.
- R3: A store whose block matches an entry that is not being drained sets that entry's slot valid bit and writes the word. Four stores to the four words of one block therefore drain as one transaction with mask 4'b1111.
- R4: A store to a slot that is already valid in a mergeable entry replaces the word, so the latest data wins.
- R5: A store that matches no mergeable entry takes a new entry. Only its own slot is marked valid, and its other data words are zero. Entries drain in allocation order.
- R6: While `mem_valid`=1 and `mem_ready`=0, the values of `mem_valid`, `mem_addr`, `mem_mask` and `mem_data` stay unchanged. `mem_addr` is the block base address (low 5 bits zero). `mem_data` carries slot n in bits [64n+63:64n]. The entry is freed on the cycle that `mem_ready`=1.
- R7: A store to the block of the entry being drained is not merged into it and takes a new entry.
- R8: When all four entries are in use, a store that matches no mergeable entry sees `st_ready`=0 and changes nothing. A store that does match is still accepted.
- R9: A read with `rd_valid`=1 gives `rd_hit`=1 exactly when an entry, including the one being drained, holds that block with the requested slot valid. In that case `rd_data` is the word.
- R10: A read of an invalid slot of a buffered block gives `rd_hit`=0, even when other slots of that block are valid.
- R11: When two entries hold the same word, a read returns the copy from the newer entry.
- R12: `full` is 1 exactly when four entries are in use, and `empty` is 1 exactly when none are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_addr | input | 32 | Store byte address |
| st_data | input | 64 | Store word |
| st_ready | output | 1 | Store accepted this cycle |
| rd_valid | input | 1 | Read-miss lookup request |
| rd_addr | input | 32 | Lookup byte address |
| rd_hit | output | 1 | Word found in the buffer |
| rd_data | output | 64 | Forwarded word |
| mem_valid | output | 1 | Block write offered to memory |
| mem_addr | output | 32 | Block base address |
| mem_mask | output | 4 | Valid word slots of the block |
| mem_data | output | 256 | Block data, slot 0 in the low bits |
| mem_ready | input | 1 | Memory accepts the block write |
| full | output | 1 | All entries in use |
| empty | output | 1 | No entries in use |

## Verification
The bench first keeps memory stalled so that one entry stays in `DR_SEND`. It then stores to the block of that entry. A design that merged such a store into the draining entry would change a transaction that memory may already be taking, and the later drain masks show this. Reads go after a partially filled block and after a word held by both an old and a new entry. Wrong slot masking shows up as a false hit, and wrong age priority shows up as the stale word being returned. With the buffer full, a store that must stall is held several cycles and then looked up to show it left no trace. A matching store is accepted at that point, which catches a design that gates `st_ready` on `full` alone. Finally every drain is compared for order, mask, address and data, which exposes lost merges, missing overwrites and non-zero unwritten slots.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

    typedef enum logic [0:0] {
        DR_IDLE = 1'b0,
        DR_SEND = 1'b1
    } drain_state_t;

endpackage

// File: rtl/mwb_probe.sv
module mwb_probe #(
    parameter int BLK_W = 27
) (
    input  logic             valid,
    input  logic [BLK_W-1:0] blk,
    input  logic [BLK_W-1:0] probe_blk,
    output logic             blk_hit
);
    assign blk_hit = valid && (blk == probe_blk);
endmodule

// File: rtl/mwb_drain_fsm.sv
module mwb_drain_fsm
    import mwb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic mem_ready,
    output logic active,
    output logic retire
);
    drain_state_t state, state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= DR_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            DR_IDLE: if (pending)   state_nxt = DR_SEND;   // start_drain
            DR_SEND: if (mem_ready) state_nxt = DR_IDLE;   // retire, else hold
            default: state_nxt = DR_IDLE;
        endcase
    end

    always_comb begin
        active = 1'b0;
        retire = 1'b0;
        unique case (state)
            DR_IDLE: ;
            DR_SEND: begin
                active = 1'b1;
                retire = mem_ready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/mwb_read_fwd.sv
module mwb_read_fwd #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 4,
    parameter int WORD_W  = 64,
    localparam int PTR_W  = $clog2(ENTRIES),
    localparam int SLOT_W = $clog2(WORDS)
) (
    input  logic                                    rd_valid,
    input  logic [SLOT_W-1:0]                       rd_slot,
    input  logic [PTR_W-1:0]                        head,
    input  logic [ENTRIES-1:0]                      blk_hit,
    input  logic [ENTRIES-1:0][WORDS-1:0]           mask,
    input  logic [ENTRIES-1:0][WORDS-1:0][WORD_W-1:0] data,
    output logic                                    hit,
    output logic [WORD_W-1:0]                       word
);
    logic             found;
    logic [PTR_W-1:0] sel;

    // Walk from oldest to newest; the last match is the newest copy.
    always_comb begin
        found = 1'b0;
        sel   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            logic [PTR_W-1:0] idx;
            idx = head + PTR_W'(i);
            if (blk_hit[idx] && mask[idx][rd_slot]) begin
                found = 1'b1;
                sel   = idx;
            end
        end
    end

    assign hit  = rd_valid && found;
    assign word = hit ? data[sel][rd_slot] : '0;
endmodule

// File: rtl/merge_write_buffer.sv
module merge_write_buffer #(
    parameter int ADDR_W  = 32,
    parameter int WORD_W  = 64,
    parameter int WORDS   = 4,
    parameter int ENTRIES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_valid,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [WORD_W-1:0]       st_data,
    output logic                    st_ready,
    input  logic                    rd_valid,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic                    rd_hit,
    output logic [WORD_W-1:0]       rd_data,
    output logic                    mem_valid,
    output logic [ADDR_W-1:0]       mem_addr,
    output logic [WORDS-1:0]        mem_mask,
    output logic [WORDS*WORD_W-1:0] mem_data,
    input  logic                    mem_ready,
    output logic                    full,
    output logic                    empty
);
    localparam int OFF_W  = $clog2(WORD_W / 8);
    localparam int SLOT_W = $clog2(WORDS);
    localparam int LOW_W  = OFF_W + SLOT_W;
    localparam int BLK_W  = ADDR_W - LOW_W;
    localparam int PTR_W  = $clog2(ENTRIES);
    localparam int CNT_W  = $clog2(ENTRIES + 1);

    logic [ENTRIES-1:0]                         e_valid;
    logic [ENTRIES-1:0][BLK_W-1:0]              e_blk;
    logic [ENTRIES-1:0][WORDS-1:0]              e_mask;
    logic [ENTRIES-1:0][WORDS-1:0][WORD_W-1:0]  e_data;
    logic [PTR_W-1:0]                           head, tail;
    logic [CNT_W-1:0]                           count;

    logic [BLK_W-1:0]   st_blk, rd_blk;
    logic [SLOT_W-1:0]  st_slot, rd_slot;
    logic [ENTRIES-1:0] st_blk_hit, rd_blk_hit, drain_excl, merge_vec;
    logic               merge_any, st_fire, alloc;
    logic [PTR_W-1:0]   merge_idx;
    logic               active, retire;

    assign st_blk  = st_addr[ADDR_W-1 -: BLK_W];
    assign st_slot = st_addr[OFF_W +: SLOT_W];
    assign rd_blk  = rd_addr[ADDR_W-1 -: BLK_W];
    assign rd_slot = rd_addr[OFF_W +: SLOT_W];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_probe
        mwb_probe #(.BLK_W(BLK_W)) u_st_probe (
            .valid(e_valid[g]), .blk(e_blk[g]),
            .probe_blk(st_blk), .blk_hit(st_blk_hit[g]));
        mwb_probe #(.BLK_W(BLK_W)) u_rd_probe (
            .valid(e_valid[g]), .blk(e_blk[g]),
            .probe_blk(rd_blk), .blk_hit(rd_blk_hit[g]));
        assign drain_excl[g] = active && (head == PTR_W'(g));
    end

    assign merge_vec = st_blk_hit & ~drain_excl;
    assign merge_any = |merge_vec;

    always_comb begin
        merge_idx = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (merge_vec[i]) merge_idx = PTR_W'(i);
    end

    assign full     = (count == CNT_W'(ENTRIES));
    assign empty    = (count == '0);
    assign st_ready = merge_any || !full;
    assign st_fire  = st_valid && st_ready;
    assign alloc    = st_fire && !merge_any;

    mwb_drain_fsm u_drain (
        .clk(clk), .rst_n(rst_n), .pending(!empty),
        .mem_ready(mem_ready), .active(active), .retire(retire));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_valid <= '0;
            e_blk   <= '0;
            e_mask  <= '0;
            e_data  <= '0;
            head    <= '0;
            tail    <= '0;
            count   <= '0;
        end else begin
            if (st_fire && merge_any) begin
                e_mask[merge_idx][st_slot] <= 1'b1;
                e_data[merge_idx][st_slot] <= st_data;
            end
            if (alloc) begin
                e_valid[tail]          <= 1'b1;
                e_blk[tail]            <= st_blk;
                e_mask[tail]           <= WORDS'(1) << st_slot;
                e_data[tail]           <= '0;
                e_data[tail][st_slot]  <= st_data;
                tail                   <= tail + 1'b1;
            end
            if (retire) begin
                e_valid[head] <= 1'b0;
                head          <= head + 1'b1;
            end
            count <= count + CNT_W'(alloc) - CNT_W'(retire);
        end
    end

    assign mem_valid = active;
    assign mem_addr  = {e_blk[head], {LOW_W{1'b0}}};
    assign mem_mask  = active ? e_mask[head] : '0;
    assign mem_data  = e_data[head];

    mwb_read_fwd #(.ENTRIES(ENTRIES), .WORDS(WORDS), .WORD_W(WORD_W)) u_fwd (
        .rd_valid(rd_valid), .rd_slot(rd_slot), .head(head),
        .blk_hit(rd_blk_hit), .mask(e_mask), .data(e_data),
        .hit(rd_hit), .word(rd_data));
endmodule

// File: rtl/mwb_checker.sv
module mwb_checker #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 64,
    parameter int WORDS  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    st_valid,
    input logic                    st_ready,
    input logic                    rd_valid,
    input logic                    rd_hit,
    input logic                    mem_valid,
    input logic                    mem_ready,
    input logic [ADDR_W-1:0]       mem_addr,
    input logic [WORDS-1:0]        mem_mask,
    input logic [WORDS*WORD_W-1:0] mem_data,
    input logic                    full,
    input logic                    empty
);
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
            && $stable(mem_mask) && $stable(mem_data));

    assert_mask_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_mask != '0);

    assert_flags_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_idle_when_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !mem_valid && !rd_hit);

    assert_stall_only_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && !st_ready |-> full);

    assert_hit_needs_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> rd_valid);

    assert_empty_after_retire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty) |-> $past(mem_valid && mem_ready));
endmodule

bind merge_write_buffer mwb_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_mwb_chk (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .rd_valid(rd_valid), .rd_hit(rd_hit), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_mask(mem_mask),
    .mem_data(mem_data), .full(full), .empty(empty));

// File: tb/test_merge_write_buffer.sv
module test_merge_write_buffer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 1'b0, rd_valid = 1'b0, mem_ready = 1'b0;
    logic [31:0] st_addr = '0, rd_addr = '0;
    logic [63:0] st_data = '0;
    logic st_ready, rd_hit, mem_valid, full, empty;
    logic [63:0] rd_data;
    logic [31:0] mem_addr;
    logic [3:0] mem_mask;
    logic [255:0] mem_data;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;

    merge_write_buffer i_merge_write_buffer (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_ready(st_ready), .rd_valid(rd_valid),
        .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_data(rd_data),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_mask(mem_mask),
        .mem_data(mem_data), .mem_ready(mem_ready), .full(full), .empty(empty));

    typedef struct packed {
        logic        is_rd;
        logic [31:0] addr;
        logic [63:0] data;
        logic        hit;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 32'h1000, 64'h11, 1'b1},  // R5 new entry (drains first)
        '{1'b0, 32'h2000, 64'h20, 1'b1},  // R5 new entry
        '{1'b0, 32'h2008, 64'h21, 1'b1},  // R3 merge
        '{1'b0, 32'h2010, 64'h22, 1'b1},  // R3 merge
        '{1'b0, 32'h2018, 64'h23, 1'b1},  // R3 merge
        '{1'b1, 32'h2010, 64'h22, 1'b1},  // R9
        '{1'b1, 32'h2015, 64'h22, 1'b1},  // R2 low bits ignored
        '{1'b1, 32'h2008, 64'h21, 1'b1},  // R9
        '{1'b0, 32'h2008, 64'h2F, 1'b1},  // R4 overwrite
        '{1'b1, 32'h2008, 64'h2F, 1'b1},  // R4
        '{1'b0, 32'h3010, 64'h32, 1'b1},  // R5 partial entry
        '{1'b1, 32'h3010, 64'h32, 1'b1},  // R9
        '{1'b1, 32'h3000, 64'h0,  1'b0},  // R10
        '{1'b1, 32'h3018, 64'h0,  1'b0},  // R10
        '{1'b1, 32'h4000, 64'h0,  1'b0},  // R9 absent block
        '{1'b1, 32'h1000, 64'h11, 1'b1},  // R9 draining entry visible
        '{1'b0, 32'h1008, 64'h18, 1'b1},  // R7 new entry, not merged
        '{1'b1, 32'h1008, 64'h18, 1'b1},  // R7
        '{1'b1, 32'h1000, 64'h11, 1'b1},  // R11 only old copy so far
        '{1'b0, 32'h1000, 64'h1A, 1'b1},  // R8 matching store while full
        '{1'b1, 32'h1000, 64'h1A, 1'b1}   // R11 newest wins
    };

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drain_one(input logic [31:0] ea, input logic [3:0] em, input logic [255:0] ed);
        for (int k = 0; k < 20 && !mem_valid; k++) @(negedge clk);
        check("R5 drain order addr", 256'(mem_addr), 256'(ea));
        check("R3 drain mask", 256'(mem_mask), 256'(em));
        check("R6 drain data", mem_data, ed);
        mem_ready = 1'b1;
        @(negedge clk);
        mem_ready = 1'b0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000) begin
                n_fail++; n_chk++;
                $display("FAIL watchdog actual=%0d expected<=5000", cyc);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 empty", 256'(empty), 256'(1));
        check("R1 full", 256'(full), 256'(0));
        check("R1 mem_valid", 256'(mem_valid), 256'(0));
        rd_valid = 1'b1; rd_addr = 32'h1000; #1;
        check("R1 rd_hit", 256'(rd_hit), 256'(0));
        rd_valid = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            if (TBL[v].is_rd) begin
                rd_valid = 1'b1; rd_addr = TBL[v].addr; #1;
                check("R9 table hit", 256'(rd_hit), 256'(TBL[v].hit));
                if (TBL[v].hit) check("R9 table data", 256'(rd_data), 256'(TBL[v].data));
                rd_valid = 1'b0;
                @(negedge clk);
            end else begin
                st_valid = 1'b1; st_addr = TBL[v].addr; st_data = TBL[v].data; #1;
                check("R8 table st_ready", 256'(st_ready), 256'(1));
                @(negedge clk);
                st_valid = 1'b0;
            end
        end

        check("R12 full", 256'(full), 256'(1));
        check("R12 not empty", 256'(empty), 256'(0));

        // R8: non-matching store while full stalls and leaves no trace
        st_valid = 1'b1; st_addr = 32'h5000; st_data = 64'h55;
        for (int k = 0; k < 3; k++) begin
            #1 check("R8 stall", 256'(st_ready), 256'(0));
            @(negedge clk);
        end
        st_valid = 1'b0;
        rd_valid = 1'b1; rd_addr = 32'h5000; #1;
        check("R8 stalled store absent", 256'(rd_hit), 256'(0));
        rd_valid = 1'b0;

        // R6 hold while memory stalls
        check("R6 offer held", 256'(mem_valid), 256'(1));
        @(negedge clk);
        check("R6 addr stable", 256'(mem_addr), 256'(32'h1000));

        drain_one(32'h1000, 4'b0001, {192'h0, 64'h11});
        check("R12 not full after retire", 256'(full), 256'(0));
        drain_one(32'h2000, 4'b1111, {64'h23, 64'h22, 64'h2F, 64'h20});
        drain_one(32'h3000, 4'b0100, {64'h0, 64'h32, 128'h0});
        drain_one(32'h1000, 4'b0011, {128'h0, 64'h18, 64'h1A});
        #1;
        check("R12 empty at end", 256'(empty), 256'(1));
        rd_valid = 1'b1; rd_addr = 32'h1000; #1;
        check("R9 freed entry miss", 256'(rd_hit), 256'(0));
        rd_valid = 1'b0;
        @(negedge clk);
        check("R6 no offer when empty", 256'(mem_valid), 256'(0));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule